// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block turns a fast module clock into the serial clock for a shift engine. It reads one control word. The word holds a linear divisor field, an exponent field and a law-select bit. When the law-select bit is set, the serial clock runs at the module clock divided by twice one more than the linear field. When the bit is clear, it runs at the module clock divided by two raised to the exponent. Software chooses the law and the field values; this block only turns them into timing.

When enabled, the block drives a free-running serial clock level. It also drives a one-cycle tick that marks every transition of that level, so the shift engine can launch and capture data on the tick. While disabled, the block does three things: it holds the serial clock at a caller-chosen idle level, it holds its half-period counter at zero, and it keeps loading the control word. The divide ratio in use is therefore the one present just before enable rose. Writes made during a run are ignored until the next enable.

Top module: `sclk_dual_div`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sclk` and `half_tick` are both 0 after that edge, whatever the other inputs are.
- R2: With `ctrl_word[12]` = 1 (linear law) and linear field `ctrl_word[7:0]` = N, `sclk` changes level on every (N+1)-th enabled clock edge, giving a period of 2*(N+1) module clocks. N = 0 gives divide-by-2.
- R3: With `ctrl_word[12]` = 0 (exponential law) and exponent field `ctrl_word[11:8]` = E, where E ≥ 1, `sclk` changes level on every 2^(E-1)-th enabled clock edge, giving a period of 2^E module clocks.
- R4: In the exponential law, E = 0 is clamped to divide-by-2, so `sclk` changes level on every enabled edge.
- R5: `half_tick` is high for exactly the cycle after each edge at which `sclk` changes level while enabled, and is low otherwise. With h the half period in module clocks, the first change after `en` rises comes at the h-th edge with `en` high.
- R6: The control word is loaded only at edges where `en` is low. Changes to the word while `en` is high have no effect until `en` has been low for at least one edge.
- R7: At an edge where `en` is low, the half-period count returns to zero, `half_tick` goes to 0, and `sclk` takes the value of `idle_lvl`. A following enable starts a fresh half period.
- R8: The law-select bit alone decides which field is used. The linear field has no effect in the exponential law, and the exponent field has no effect in the linear law.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the divider idle and loads the control word |
| ctrl_word | input | 13 | Bit 12 selects the law (1 linear, 0 exponential); bits 11:8 hold the exponent; bits 7:0 hold the linear divisor |
| idle_lvl | input | 1 | Level `sclk` holds while disabled |
| sclk | output | 1 | Divided serial clock level |
| half_tick | output | 1 | One-cycle pulse marking each `sclk` transition |

## Verification
The hardest case to reach from the ports is the longest half period in the exponential law. With E = 15, one half period lasts 16384 module clocks. A short run would never see a transition, so the bench sweeps every exponent and every linear value. Each run lasts through the second transition, and the bench compares `sclk` and `half_tick` on every cycle against an arithmetic model. The bench also rewrites the control word and drops enable partway through a half period. This shows that the running ratio is held and that the count restarts from zero.

// File: rtl/sclk_div_pkg.sv
// Package: shared defaults and the law-select encoding for the serial
// clock divider. Assumes nothing beyond being compiled first.
package sclk_div_pkg;

    // Default width of the linear divisor field.
    localparam int DEF_LIN_W = 8;
    // Default width of the exponent field.
    localparam int DEF_EXP_W = 4;

    // Encoding of the law-select bit in the control word.
    typedef enum logic {
        LAW_EXP = 1'b0,
        LAW_LIN = 1'b1
    } div_law_e;

    // Larger of two integers, used to size the half-period counter.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sclk_half_calc.sv
// Decodes a control word into a terminal count, which is the half period
// minus one. Purely combinational.
// Assumes CNT_W is large enough for both 2^LIN_W and 2^(2^EXP_W - 2).
module sclk_half_calc
    import sclk_div_pkg::*;
#(
    parameter int LIN_W = DEF_LIN_W,
    parameter int EXP_W = DEF_EXP_W,
    parameter int CNT_W = 15,
    localparam int WORD_W = LIN_W + EXP_W + 1
) (
    input  logic [WORD_W-1:0] ctrl_word,
    output logic [CNT_W-1:0]  term_cnt
);

    div_law_e             law;
    logic [LIN_W-1:0]     lin_fld;
    logic [EXP_W-1:0]     exp_fld;
    logic [CNT_W-1:0]     lin_tc;
    logic [CNT_W-1:0]     exp_tc;

    // Split the control word into its law bit and its two fields.
    always_comb begin
        law     = div_law_e'(ctrl_word[WORD_W-1]);
        lin_fld = ctrl_word[LIN_W-1:0];
        exp_fld = ctrl_word[LIN_W+EXP_W-1:LIN_W];
    end

    // Linear law: the half period is N+1, so the terminal count is N.
    always_comb begin
        lin_tc = {{(CNT_W-LIN_W){1'b0}}, lin_fld};
    end

    // Exponential law: the terminal count is 2^(E-1)-1, which is a run of
    // E-1 low ones. E of 0 or 1 gives 0, i.e. divide-by-2.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            exp_tc[i] = ((i + 1) < int'(exp_fld));
        end
    end

    // Pick the terminal count of the selected law.
    always_comb begin
        term_cnt = (law == LAW_LIN) ? lin_tc : exp_tc;
    end

endmodule

// File: rtl/sclk_cfg_hold.sv
// Holds the decoded terminal count. It loads only while the divider is
// idle, so a run keeps the ratio present just before enable rose.
// Synchronous active-low reset.
module sclk_cfg_hold #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] term_in,
    output logic [CNT_W-1:0] term_q
);

    // Load the terminal count on idle cycles, hold it while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q <= '0;
        end else if (!en) begin
            term_q <= term_in;
        end
    end

endmodule

// File: rtl/sclk_half_counter.sv
// Counts module clocks within one half period. It raises a combinational
// hit on the terminal count and registers that hit as the tick output.
// Assumes term_q is stable while en is high.
module sclk_half_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] term_q,
    output logic             hit,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    // Terminal count reached on an enabled cycle.
    always_comb begin
        hit = en && (cnt_q == term_q);
    end

    // Advance or wrap the half-period count; clear it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Register the hit as a one-cycle tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            tick <= hit;
        end
    end

endmodule

// File: rtl/sclk_level_gen.sv
// Drives the serial clock level. It toggles on each hit while running and
// follows the idle level while disabled. Synchronous active-low reset to 0.
module sclk_level_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit,
    input  logic idle_lvl,
    output logic sclk
);

    // Toggle on hit, park at the idle level when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk <= 1'b0;
        end else if (!en) begin
            sclk <= idle_lvl;
        end else if (hit) begin
            sclk <= ~sclk;
        end
    end

endmodule

// File: rtl/sclk_dual_div.sv
// Top of the dual-law serial clock divider. It decodes the control word,
// holds the result while running, counts half periods and drives the clock
// level and the transition tick. Assumes one clock domain and a
// synchronous active-low reset.
module sclk_dual_div
    import sclk_div_pkg::*;
#(
    parameter int LIN_W = DEF_LIN_W,
    parameter int EXP_W = DEF_EXP_W,
    localparam int WORD_W = LIN_W + EXP_W + 1,
    localparam int CNT_W  = max_of(LIN_W + 1, (1 << EXP_W) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic              idle_lvl,
    output logic              sclk,
    output logic              half_tick
);

    logic [CNT_W-1:0] term_raw;
    logic [CNT_W-1:0] term_q;
    logic             hit;

    // Decode the word into a terminal count.
    sclk_half_calc #(
        .LIN_W (LIN_W),
        .EXP_W (EXP_W),
        .CNT_W (CNT_W)
    ) u_calc (
        .ctrl_word (ctrl_word),
        .term_cnt  (term_raw)
    );

    // Hold the terminal count while running.
    sclk_cfg_hold #(
        .CNT_W (CNT_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .term_in (term_raw),
        .term_q  (term_q)
    );

    // Count half periods and produce the tick.
    sclk_half_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .term_q (term_q),
        .hit    (hit),
        .tick   (half_tick)
    );

    // Drive the serial clock level.
    sclk_level_gen u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .hit      (hit),
        .idle_lvl (idle_lvl),
        .sclk     (sclk)
    );

endmodule

// File: rtl/sclk_dual_div_chk.sv
// Checker for the divider, bound to the top. It watches only ports and
// keeps its own count of the spacing between ticks.
module sclk_dual_div_chk #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int WORD_W = LIN_W + EXP_W + 1,
    localparam int GAP_W  = LIN_W + (1 << EXP_W) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [WORD_W-1:0] ctrl_word,
    input logic              idle_lvl,
    input logic              sclk,
    input logic              half_tick
);

    logic [GAP_W-1:0] c_gap;
    logic [GAP_W-1:0] c_last;
    logic [1:0]       c_seen;

    // Measure the spacing between ticks within one enabled run.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            c_gap  <= '0;
            c_last <= '0;
            c_seen <= 2'd0;
        end else if (half_tick) begin
            c_gap <= 1;
            if (c_seen != 2'd0) begin
                c_last <= c_gap;
            end
            if (c_seen != 2'd2) begin
                c_seen <= c_seen + 2'd1;
            end
        end else begin
            c_gap <= c_gap + 1'b1;
        end
    end

    // R5: a tick always comes with a change of level
    a_r5_tick_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && half_tick) |-> (sclk != $past(sclk)));

    // R5: while enabled, a change of level always comes with a tick
    a_r5_edge_has_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && (sclk != $past(sclk))) |-> half_tick);

    // R7: a disabled edge parks the clock at the idle level with no tick
    a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> (!half_tick && (sclk == $past(idle_lvl))));

    // R6: within one run, ticks after the first keep a fixed spacing
    a_r6_steady_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (en && half_tick && (c_seen == 2'd2)) |-> (c_gap == c_last));

endmodule

bind sclk_dual_div sclk_dual_div_chk #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ctrl_word (ctrl_word),
    .idle_lvl  (idle_lvl),
    .sclk      (sclk),
    .half_tick (half_tick)
);

// File: tb/tb_sclk_dual_div.sv
module tb_sclk_dual_div;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [12:0] ctrl_word = '0;
    logic        idle_lvl = 1'b0;
    logic        sclk;
    logic        half_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sclk_dual_div dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ctrl_word (ctrl_word),
        .idle_lvl  (idle_lvl),
        .sclk      (sclk),
        .half_tick (half_tick)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Disable, load a word, and confirm the idle state (R7).
    task automatic setup(input logic [12:0] word, input logic idle);
        @(negedge clk);
        en = 1'b0;
        ctrl_word = word;
        idle_lvl = idle;
        @(negedge clk);
        @(negedge clk);
        chk("R7 idle level", int'(sclk), int'(idle));
        chk("R7 idle tick", int'(half_tick), 0);
    endtask

    // Check cycles n0..n1 after enable against half period h.
    task automatic span(input int h, input logic idle, input int n0, input int n1,
                        input string req);
        for (int n = n0; n <= n1; n++) begin
            @(negedge clk);
            chk(req, int'(half_tick), (n % h == 0) ? 1 : 0);
            chk(req, int'(sclk), int'(idle) ^ ((n / h) % 2));
        end
    endtask

    initial begin
        // R1: reset dominates all other inputs
        en = 1'b1;
        idle_lvl = 1'b1;
        ctrl_word = 13'h1000;
        repeat (4) @(negedge clk);
        chk("R1 reset sclk", int'(sclk), 0);
        chk("R1 reset tick", int'(half_tick), 0);
        en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2 and R8: every linear value, exponent field holds junk
        for (int nv = 0; nv < 256; nv++) begin
            logic idl;
            idl = nv[0];
            setup({1'b1, nv[3:0] ^ 4'hF, nv[7:0]}, idl);
            en = 1'b1;
            span(nv + 1, idl, 1, 2 * (nv + 1) + 1, "R2 R8 linear");
        end

        // R3, R4 and R8: every exponent, linear field holds junk
        for (int ev = 0; ev < 16; ev++) begin
            logic idl;
            int   h;
            idl = ~ev[0];
            h = (ev <= 1) ? 1 : (1 << (ev - 1));
            setup({1'b0, ev[3:0], 8'hA5}, idl);
            en = 1'b1;
            span(h, idl, 1, 2 * h + 1, (ev == 0) ? "R4 clamp" : "R3 R8 exponential");
        end

        // R8: the same fields under both laws
        setup({1'b1, 4'd3, 8'd6}, 1'b0);
        en = 1'b1;
        span(7, 1'b0, 1, 15, "R8 law linear");
        setup({1'b0, 4'd3, 8'd6}, 1'b0);
        en = 1'b1;
        span(4, 1'b0, 1, 9, "R8 law exponential");

        // R6: a rewrite during a run is ignored until the next enable
        setup({1'b1, 4'd0, 8'd2}, 1'b1);
        en = 1'b1;
        span(3, 1'b1, 1, 4, "R6 before rewrite");
        ctrl_word = {1'b1, 4'd0, 8'd9};
        span(3, 1'b1, 5, 13, "R6 after rewrite");
        setup({1'b1, 4'd0, 8'd9}, 1'b1);
        en = 1'b1;
        span(10, 1'b1, 1, 21, "R6 new ratio");

        // R7 and R5: drop enable mid half period, then restart fresh
        setup({1'b1, 4'd0, 8'd4}, 1'b0);
        en = 1'b1;
        span(5, 1'b0, 1, 7, "R5 run");
        en = 1'b0;
        idle_lvl = 1'b1;
        @(negedge clk);
        chk("R7 drop sclk", int'(sclk), 1);
        chk("R7 drop tick", int'(half_tick), 0);
        @(negedge clk);
        chk("R7 hold sclk", int'(sclk), 1);
        en = 1'b1;
        span(5, 1'b1, 1, 11, "R7 restart");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule